// File: doc/BRIEF.md
# Two-Bank Interrupt Status and Mask Register Block

This block collects interrupt events from a neighbouring engine into two independent 32-bit status words, a normal bank and an error bank. Each bank has its own 32-bit mask, where a set mask bit blocks the matching status bit from reaching the interrupt line. Hardware raises status bits by pulsing event vectors, one vector per bank. Software reaches the block through a simple register port with a valid strobe, a write flag, a byte address and 32-bit data.

Software never writes a mask directly. For each bank there is one address that unmasks: each one bit in the written word clears that mask bit. A second address masks: each one bit sets that mask bit. Status bits are cleared by writing ones to the status address. A single registered, level-sensitive interrupt output is high while any unmasked status bit is set in either bank.

The two banks reset to different masks. Every normal source below bit 27 starts masked, and so does every error source.

Top module: `irq_sm_top`

## Requirements
- R1: After reset both status words read 0, the normal mask at address 0x08 reads 0x07FFFFFF, the error mask at address 0x18 reads 0xFFFFFFFF, and irqOut is 0.
- R2: A valid read (regValid=1, regWrite=0) returns the same cycle on regRdata: normal status at 0x04, normal mask at 0x08, error status at 0x14, error mask at 0x18.
- R3: A write to 0x04 (normal) or 0x14 (error) clears each status bit whose data bit is 1 and leaves the other status bits unchanged, from the next cycle.
- R4: A write to 0x0C (normal) or 0x1C (error) clears the mask bits of that bank where the data is 1, from the next cycle.
- R5: A write to 0x10 (normal) or 0x20 (error) sets the mask bits of that bank where the data is 1, from the next cycle.
- R6: A write to a mask address (0x08 or 0x18) changes no mask bit.
- R7: Each 1 bit on evtNormal (normal bank) or evtError (error bank) sets that status bit at the next clock edge, whatever its mask.
- R8: When an event bit and a status-clear write hit the same bit in the same cycle, the bit ends up set.
- R9: irqOut in each cycle equals the OR, taken over both banks, of (status AND NOT mask) as it stood in the previous cycle.
- R10: Reads of 0x0C, 0x10, 0x1C, 0x20, reads of any unmapped address, and regRdata whenever no valid read is in progress all give 0. Writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access strobe for this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 12 | Byte address, word aligned |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational, zero unless a valid read |
| evtNormal | input | 32 | Event pulses for the normal bank |
| evtError | input | 32 | Event pulses for the error bank |
| irqOut | output | 1 | Level interrupt, registered |

## Verification
A wrong status or mask bit shows up at the ports in two ways. It is returned on the next read of that bank's status or mask address. It also shows on irqOut exactly one clock after the bad state arises, provided the bit is unmasked. The bench tracks both banks in a model, reads the block back after every directed step and at random points of a long random run, and compares irqOut in every cycle. A fault therefore shows up within a cycle of the first access that exposes it. The collision between a set and a clear on the same bit, and the ignored direct mask writes, are each followed at once by a read of the affected register.

// File: rtl/irq_sm_pkg.sv
package irq_sm_pkg;

  localparam int NUM_BANKS   = 2;
  localparam int BANK_BASE   = 'h04;
  localparam int BANK_STRIDE = 'h10;

  // word slot inside a bank, in address order
  typedef enum int {
    SLOT_STATUS  = 0,
    SLOT_MASK    = 1,
    SLOT_UNMASK  = 2,
    SLOT_MASKSET = 3
  } slot_e;

  typedef struct packed {
    logic [NUM_BANKS-1:0] stsClr;
    logic [NUM_BANKS-1:0] mskClr;
    logic [NUM_BANKS-1:0] mskSet;
    logic [NUM_BANKS-1:0] rdSts;
    logic [NUM_BANKS-1:0] rdMsk;
  } strobe_t;

  function automatic int slotAddr(input int bank, input slot_e slot);
    return BANK_BASE + bank * BANK_STRIDE + int'(slot) * 4;
  endfunction

endpackage

// File: rtl/irq_sm_ctrl.sv
module irq_sm_ctrl
  import irq_sm_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strobes
);

  logic wrAcc;
  logic rdAcc;

  assign wrAcc = regValid && regWrite;
  assign rdAcc = regValid && !regWrite;

  always_comb begin
    strobes = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      strobes.stsClr[b] = wrAcc && (regAddr == ADDR_W'(slotAddr(b, SLOT_STATUS)));
      strobes.mskClr[b] = wrAcc && (regAddr == ADDR_W'(slotAddr(b, SLOT_UNMASK)));
      strobes.mskSet[b] = wrAcc && (regAddr == ADDR_W'(slotAddr(b, SLOT_MASKSET)));
      strobes.rdSts[b]  = rdAcc && (regAddr == ADDR_W'(slotAddr(b, SLOT_STATUS)));
      strobes.rdMsk[b]  = rdAcc && (regAddr == ADDR_W'(slotAddr(b, SLOT_MASK)));
    end
  end

endmodule

// File: rtl/irq_sm_dp.sv
module irq_sm_dp
  import irq_sm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [NUM_BANKS-1:0][DATA_W-1:0] MASK_RST = '1
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  strobe_t                            strobes,
  input  logic [DATA_W-1:0]                  wdata,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]   evtVec,
  output logic [DATA_W-1:0]                  rdata,
  output logic [NUM_BANKS-1:0][DATA_W-1:0]   stsVec,
  output logic [NUM_BANKS-1:0][DATA_W-1:0]   mskVec,
  output logic                               irqOut
);

  logic [NUM_BANKS-1:0] bankPend;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] clrBits;
    logic [DATA_W-1:0] unmaskBits;
    logic [DATA_W-1:0] maskBits;

    assign clrBits    = strobes.stsClr[b] ? wdata : '0;
    assign unmaskBits = strobes.mskClr[b] ? wdata : '0;
    assign maskBits   = strobes.mskSet[b] ? wdata : '0;

    // events applied after the clear so a simultaneous set survives
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stsVec[b] <= '0;
        mskVec[b] <= MASK_RST[b];
      end else begin
        stsVec[b] <= (stsVec[b] & ~clrBits) | evtVec[b];
        mskVec[b] <= (mskVec[b] & ~unmaskBits) | maskBits;
      end
    end

    assign bankPend[b] = |(stsVec[b] & ~mskVec[b]);
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strobes.rdSts[b]) rdata = rdata | stsVec[b];
      if (strobes.rdMsk[b]) rdata = rdata | mskVec[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |bankPend;
  end

endmodule

// File: rtl/irq_sm_top.sv
module irq_sm_top
  import irq_sm_pkg::*;
#(
  parameter int              ADDR_W        = 12,
  parameter int              DATA_W        = 32,
  parameter logic [DATA_W-1:0] NORM_MASK_RST = 32'h07FF_FFFF,
  parameter logic [DATA_W-1:0] ERR_MASK_RST  = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [DATA_W-1:0] evtNormal,
  input  logic [DATA_W-1:0] evtError,
  output logic              irqOut
);

  strobe_t                             strobes;
  logic [NUM_BANKS-1:0][DATA_W-1:0]    evtVec;
  logic [NUM_BANKS-1:0][DATA_W-1:0]    stsVec;
  logic [NUM_BANKS-1:0][DATA_W-1:0]    mskVec;

  assign evtVec = {evtError, evtNormal};

  irq_sm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .strobes  (strobes)
  );

  irq_sm_dp #(
    .DATA_W   (DATA_W),
    .MASK_RST ({ERR_MASK_RST, NORM_MASK_RST})
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wdata   (regWdata),
    .evtVec  (evtVec),
    .rdata   (regRdata),
    .stsVec  (stsVec),
    .mskVec  (mskVec),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/irq_sm_chk.sv
module irq_sm_chk
  import irq_sm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             regValid,
  input logic                             regWrite,
  input logic [ADDR_W-1:0]                regAddr,
  input logic [DATA_W-1:0]                regWdata,
  input logic [DATA_W-1:0]                regRdata,
  input logic [NUM_BANKS-1:0][DATA_W-1:0] evtVec,
  input logic [NUM_BANKS-1:0][DATA_W-1:0] stsVec,
  input logic [NUM_BANKS-1:0][DATA_W-1:0] mskVec,
  input logic                             irqOut
);

  localparam logic [ADDR_W-1:0] A_NSTS = ADDR_W'(slotAddr(0, SLOT_STATUS));
  localparam logic [ADDR_W-1:0] A_NMSK = ADDR_W'(slotAddr(0, SLOT_MASK));
  localparam logic [ADDR_W-1:0] A_NUNM = ADDR_W'(slotAddr(0, SLOT_UNMASK));
  localparam logic [ADDR_W-1:0] A_NSET = ADDR_W'(slotAddr(0, SLOT_MASKSET));
  localparam logic [ADDR_W-1:0] A_EMSK = ADDR_W'(slotAddr(1, SLOT_MASK));
  localparam logic [ADDR_W-1:0] A_EUNM = ADDR_W'(slotAddr(1, SLOT_UNMASK));
  localparam logic [ADDR_W-1:0] A_ESET = ADDR_W'(slotAddr(1, SLOT_MASKSET));

  logic pendAny;
  logic wrHit;
  assign pendAny = (|(stsVec[0] & ~mskVec[0])) || (|(stsVec[1] & ~mskVec[1]));
  assign wrHit   = regValid && regWrite;

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == $past(pendAny));

  // R7
  evt_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|evtVec) |=> ((stsVec & $past(evtVec)) == $past(evtVec)));

  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && regAddr == A_NSTS && evtVec[0] == '0) |=> ((stsVec[0] & $past(regWdata)) == '0));

  // R4
  unmask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && regAddr == A_NUNM) |=> ((mskVec[0] & $past(regWdata)) == '0));

  // R5
  maskset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && regAddr == A_ESET) |=> ((mskVec[1] & $past(regWdata)) == $past(regWdata)));

  // R6
  mask_ro_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && (regAddr == A_NMSK || regAddr == A_EMSK)) |=> $stable(mskVec));

  // R10
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite && (regAddr == A_NUNM || regAddr == A_NSET ||
     regAddr == A_EUNM || regAddr == A_ESET)) |-> (regRdata == '0));

endmodule

bind irq_sm_top irq_sm_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regValid (regValid),
  .regWrite (regWrite),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .evtVec   (evtVec),
  .stsVec   (stsVec),
  .mskVec   (mskVec),
  .irqOut   (irqOut)
);

// File: tb/test_irq_sm_top.sv
`timescale 1ns/1ps
module test_irq_sm_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] evtNormal = '0;
  logic [31:0] evtError = '0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] mSts [2];
  logic [31:0] mMsk [2];
  logic        mIrq;

  always #2.5 clk = ~clk;

  irq_sm_top i_irq_sm_top (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .evtNormal(evtNormal), .evtError(evtError), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expRead(input logic v, input logic w, input logic [11:0] a);
    if (!v || w) return 32'h0;
    case (a)
      12'h004: return mSts[0];
      12'h008: return mMsk[0];
      12'h014: return mSts[1];
      12'h018: return mMsk[1];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string readTag(input logic [11:0] a);
    if (a == 12'h004 || a == 12'h008 || a == 12'h014 || a == 12'h018) return "R2";
    return "R10";
  endfunction

  // one bus cycle: drive after falling edge, check, then advance model at rising edge
  task automatic cyc(input logic v, input logic w, input logic [11:0] a,
                     input logic [31:0] d, input logic [31:0] eN, input logic [31:0] eE,
                     input string tag);
    logic [31:0] ev [2];
    logic [31:0] clr, un, st;
    logic [11:0] base;
    logic newIrq;
    @(negedge clk);
    regValid = v; regWrite = w; regAddr = a; regWdata = d;
    evtNormal = eN; evtError = eE;
    #1;
    chk("R9 irqOut", {31'h0, irqOut}, {31'h0, mIrq});
    if (v && !w) chk(tag, regRdata, expRead(v, w, a));
    if (!v) chk("R10 idle rdata", regRdata, 32'h0);
    @(posedge clk);
    ev[0] = eN; ev[1] = eE;
    newIrq = (|(mSts[0] & ~mMsk[0])) || (|(mSts[1] & ~mMsk[1]));
    for (int b = 0; b < 2; b++) begin
      base = 12'h004 + 12'(b * 16);
      clr = (v && w && a == base)         ? d : 32'h0;
      un  = (v && w && a == base + 12'h8) ? d : 32'h0;
      st  = (v && w && a == base + 12'hC) ? d : 32'h0;
      mSts[b] = (mSts[b] & ~clr) | ev[b];
      mMsk[b] = (mMsk[b] & ~un) | st;
    end
    mIrq = newIrq;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 32'h0, 32'h0, 32'h0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b1, a, d, 32'h0, 32'h0, "wr");
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] addrList [10];
    int seedVal;
    mSts[0] = 32'h0; mSts[1] = 32'h0;
    mMsk[0] = 32'h07FF_FFFF; mMsk[1] = 32'hFFFF_FFFF;
    mIrq = 1'b0;
    seedVal = $urandom(32'd2718);
    repeat (3) @(posedge clk);
    #1 chk("R1 irqOut in reset", {31'h0, irqOut}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    // R1 reset values
    rd(12'h004, "R1 normal status");
    rd(12'h008, "R1 normal mask");
    rd(12'h014, "R1 error status");
    rd(12'h018, "R1 error mask");

    // R7 event on masked normal bit 3 and unmasked bit 27 (vsync position)
    cyc(1'b0, 1'b0, 12'h0, 32'h0, 32'h0800_0008, 32'h0, "R7");
    rd(12'h004, "R7 status after events");
    cyc(1'b0, 1'b0, 12'h0, 32'h0, 32'h0, 32'h0, "R9");   // irq seen here
    // R3 clear bit 27 only
    wr(12'h004, 32'h0800_0000);
    rd(12'h004, "R3 status after w1c");
    // R4 unmask bit 3 -> irq
    wr(12'h00C, 32'h0000_0008);
    rd(12'h008, "R4 mask after unmask");
    rd(12'h00C, "R10 unmask read");
    // R8 set and clear same bit same cycle
    cyc(1'b1, 1'b1, 12'h004, 32'h0000_0008, 32'h0000_0008, 32'h0, "R8");
    rd(12'h004, "R8 set wins");
    // R6 direct mask write ignored
    wr(12'h008, 32'h0);
    rd(12'h008, "R6 normal mask unchanged");
    wr(12'h018, 32'h0);
    rd(12'h018, "R6 error mask unchanged");
    // R5 mask normal bit 3 again
    wr(12'h010, 32'h0000_0008);
    rd(12'h008, "R5 mask after set");
    // error bank
    cyc(1'b0, 1'b0, 12'h0, 32'h0, 32'h0, 32'h0000_2002, "R7");
    wr(12'h01C, 32'h0000_0002);
    rd(12'h018, "R4 error unmask");
    rd(12'h014, "R7 error status");
    wr(12'h020, 32'hFFFF_FFFF);
    rd(12'h018, "R5 error mask all");
    rd(12'h020, "R10 disable read");
    // R10 unmapped write ignored
    wr(12'h040, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h004, "R10 status after unmapped write");
    rd(12'h008, "R10 mask after unmapped write");
    rd(12'h000, "R10 unmapped read");

    addrList = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010,
                 12'h014, 12'h018, 12'h01C, 12'h020, 12'h040};
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      logic v, w;
      logic [31:0] d;
      a = addrList[$urandom % 10];
      v = ($urandom % 4) != 0;
      w = $urandom % 2;
      d = ($urandom % 8 == 0) ? 32'hFFFF_FFFF : $urandom;
      cyc(v, w, a, d, $urandom & $urandom & $urandom & $urandom,
          $urandom & $urandom & $urandom & $urandom, readTag(a));
    end
    for (int b = 0; b < 4; b++) rd(12'h004 + 12'(b * 4), "R2 final");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule